// File: doc/BRIEF.md
# Two-Dimensional Even Parity Checker

This block checks a frame of bytes protected by parity in two directions. Each data row arrives with one extra bit that makes that row's count of ones even. After the data rows comes a closing byte whose bit c makes column c even across all the data rows. As the rows stream in, the block works out which rows fail, keeps a running XOR of the columns and stores each byte.

When the closing parity byte arrives, the block combines it with the column XOR to find the failing columns. It then classifies the frame. A single flipped data bit sits where the one failing row meets the one failing column. The block reports that position and returns the repaired byte.

A failure in only the row-parity bits, or only the column-parity byte, is reported as a parity-bit fault. In that case no data is repaired. Any other pattern is reported as uncorrectable. The result comes out as a one-cycle strobe with status and index fields, and the internal state clears so a new frame can follow at once.

Top module: `parity2d_checker`

## Requirements
- R1: A cycle with `in_valid`=1 and `in_last`=0 delivers one data row: `in_data` is the byte and `in_par` its row parity bit. The row passes when the ones in `in_data` plus `in_par` are even in number. Rows are numbered from 0 in arrival order.
- R2: A cycle with `in_valid`=1 and `in_last`=1 delivers the column parity byte. Column c fails when the XOR of bit c over all accepted data rows, XORed with `in_data[c]`, is 1. `in_par` in that cycle has no effect.
- R3: With no failing row and no failing column, `res_status`=0 (clean), and `res_row`, `res_col` and `res_byte` are 0.
- R4: With exactly one failing row r and exactly one failing column c, `res_status`=1 (corrected), `res_row`=r and `res_col`=c. `res_byte` is the byte received in row r with bit c inverted.
- R5: With exactly one failing row r and no failing column, `res_status`=2 (parity-bit fault), `res_row`=r and `res_col`=0. With exactly one failing column c and no failing row, `res_status`=2, `res_row`=0 and `res_col`=c. In both cases `res_byte`=0.
- R6: Any other pattern of failures gives `res_status`=3 (uncorrectable), with `res_row`, `res_col` and `res_byte` all 0.
- R7: `res_valid` is 1 in exactly the cycle after each clock edge that accepts a parity byte, and 0 in every other cycle, including the cycles during reset.
- R8: Accepting a parity byte clears all frame state. The next frame, even one starting in the very next cycle, is judged only on its own rows.
- R9: A frame holds at most ROWS (default 8) data rows. Data rows beyond that count are ignored, both for the parity checks and for storage.
- R10: Cycles with `in_valid`=0 leave the frame state unchanged, whatever `in_data`, `in_par` and `in_last` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat qualifier |
| in_data | input | W (8) | Data byte or column parity byte |
| in_par | input | 1 | Row parity bit of a data row |
| in_last | input | 1 | Marks the column parity byte that ends the frame |
| res_valid | output | 1 | One-cycle result strobe |
| res_status | output | 2 | 0 clean, 1 corrected, 2 parity-bit fault, 3 uncorrectable |
| res_row | output | clog2(ROWS) | Failing row index |
| res_col | output | clog2(W) | Failing column index |
| res_byte | output | W | Repaired byte when corrected, else 0 |

## Verification
Every result is due exactly one clock after the edge that takes in the parity byte. Row beats and idle beats produce no strobe, so in those cycles the result strobe must be low. The bench's behavioural model updates its expected outputs after driving each beat and applies them at the following falling edge. It compares the strobe in every cycle and the fields whenever a strobe is expected. This keeps each check aligned with the single register stage between the inputs and the result.

// File: rtl/parity2d_pkg.sv
package parity2d_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIX   = 2'd1,
    ST_PAR   = 2'd2,
    ST_BAD   = 2'd3
  } p2d_status_e;

endpackage

// File: rtl/p2d_accum.sv
module p2d_accum #(
  parameter int W    = 8,
  parameter int ROWS = 8,
  localparam int RW   = $clog2(ROWS),
  localparam int CNTW = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_last,
  input  logic [W-1:0]    in_data,
  input  logic            in_par,
  output logic            row_we,
  output logic [RW-1:0]   row_waddr,
  output logic            frame_end,
  output logic [W-1:0]    col_acc,
  output logic [ROWS-1:0] row_fail
);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [W-1:0]    col_q, col_d;
  logic [ROWS-1:0] fail_q, fail_d;
  logic            room;

  assign room      = (cnt_q < CNTW'(ROWS));
  assign row_we    = in_valid & ~in_last & room;
  assign frame_end = in_valid & in_last;
  assign row_waddr = cnt_q[RW-1:0];
  assign col_acc   = col_q;
  assign row_fail  = fail_q;

  always_comb begin
    cnt_d  = cnt_q;
    col_d  = col_q;
    fail_d = fail_q;
    if (frame_end) begin
      cnt_d  = '0;
      col_d  = '0;
      fail_d = '0;
    end else if (row_we) begin
      cnt_d             = cnt_q + CNTW'(1);
      col_d             = col_q ^ in_data;
      fail_d[row_waddr] = ^{in_par, in_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      col_q  <= '0;
      fail_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      col_q  <= col_d;
      fail_q <= fail_d;
    end
  end

  // R8: a parity byte leaves the row counter and fail vector empty
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (cnt_q == '0 && fail_q == '0));

  // R9: the row count never passes the frame capacity
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(ROWS));

  // R10: idle beats leave the frame state untouched
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cnt_q) && $stable(col_q) && $stable(fail_q)));

endmodule

// File: rtl/p2d_row_store.sv
module p2d_row_store #(
  parameter int W    = 8,
  parameter int ROWS = 8,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [RW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic row_en;
    assign row_en = we && (waddr == RW'(g));
    always_ff @(posedge clk) begin
      if (row_en) mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/p2d_classify.sv
module p2d_classify
  import parity2d_pkg::*;
#(
  parameter int W    = 8,
  parameter int ROWS = 8,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(W)
) (
  input  logic [ROWS-1:0] row_fail,
  input  logic [W-1:0]    col_fail,
  output p2d_status_e     status,
  output logic [RW-1:0]   row_idx,
  output logic [CW-1:0]   col_idx
);

  logic          r_any, r_one, c_any, c_one;
  logic [RW-1:0] r_enc;
  logic [CW-1:0] c_enc;

  assign r_any = |row_fail;
  assign r_one = r_any && ((row_fail & (row_fail - ROWS'(1))) == '0);
  assign c_any = |col_fail;
  assign c_one = c_any && ((col_fail & (col_fail - W'(1))) == '0);

  always_comb begin
    r_enc = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (row_fail[i]) r_enc = RW'(i);
    end
  end

  always_comb begin
    c_enc = '0;
    for (int i = 0; i < W; i++) begin
      if (col_fail[i]) c_enc = CW'(i);
    end
  end

  always_comb begin
    if (!r_any && !c_any)                       status = ST_CLEAN;
    else if (r_one && c_one)                    status = ST_FIX;
    else if ((r_one && !c_any) || (c_one && !r_any)) status = ST_PAR;
    else                                        status = ST_BAD;
  end

  assign row_idx = (status == ST_BAD) ? '0 : r_enc;
  assign col_idx = (status == ST_BAD) ? '0 : c_enc;

endmodule

// File: rtl/parity2d_checker.sv
module parity2d_checker
  import parity2d_pkg::*;
#(
  parameter int W    = 8,
  parameter int ROWS = 8,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic          in_par,
  input  logic          in_last,
  output logic          res_valid,
  output logic [1:0]    res_status,
  output logic [RW-1:0] res_row,
  output logic [CW-1:0] res_col,
  output logic [W-1:0]  res_byte
);

  logic            row_we, frame_end;
  logic [RW-1:0]   row_waddr;
  logic [W-1:0]    col_acc, col_fail, rd_byte, fix_byte;
  logic [ROWS-1:0] row_fail;
  p2d_status_e     cls_status;
  logic [RW-1:0]   cls_row;
  logic [CW-1:0]   cls_col;

  p2d_accum #(.W(W), .ROWS(ROWS)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_data   (in_data),
    .in_par    (in_par),
    .row_we    (row_we),
    .row_waddr (row_waddr),
    .frame_end (frame_end),
    .col_acc   (col_acc),
    .row_fail  (row_fail)
  );

  p2d_row_store #(.W(W), .ROWS(ROWS)) u_store (
    .clk   (clk),
    .we    (row_we),
    .waddr (row_waddr),
    .wdata (in_data),
    .raddr (cls_row),
    .rdata (rd_byte)
  );

  assign col_fail = col_acc ^ in_data;

  p2d_classify #(.W(W), .ROWS(ROWS)) u_cls (
    .row_fail (row_fail),
    .col_fail (col_fail),
    .status   (cls_status),
    .row_idx  (cls_row),
    .col_idx  (cls_col)
  );

  assign fix_byte = (cls_status == ST_FIX) ? (rd_byte ^ (W'(1) << cls_col)) : '0;

  logic          val_d;
  logic [1:0]    st_d;
  logic [RW-1:0] row_d;
  logic [CW-1:0] col_d;
  logic [W-1:0]  byte_d;

  always_comb begin
    val_d  = frame_end;
    st_d   = res_status;
    row_d  = res_row;
    col_d  = res_col;
    byte_d = res_byte;
    if (frame_end) begin
      st_d   = cls_status;
      row_d  = cls_row;
      col_d  = cls_col;
      byte_d = fix_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_status <= '0;
      res_row    <= '0;
      res_col    <= '0;
      res_byte   <= '0;
    end else begin
      res_valid  <= val_d;
      res_status <= st_d;
      res_row    <= row_d;
      res_col    <= col_d;
      res_byte   <= byte_d;
    end
  end

  // R7: strobe follows each accepted parity byte by one cycle
  p_strobe_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> res_valid);
  p_strobe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !res_valid);

  // R4: a correction is only claimed for one failing row and one failing column
  p_fix_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_status == ST_FIX) |-> ($countones(row_fail) == 1 && $countones(col_fail) == 1));

  // R6: uncorrectable results carry zeroed fields
  p_bad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'd3) |-> (res_row == '0 && res_col == '0 && res_byte == '0));

endmodule

// File: tb/parity2d_checker_tb.sv
module parity2d_checker_tb;

  localparam int W    = 8;
  localparam int ROWS = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_par, in_last;
  logic [7:0] in_data;
  logic       res_valid;
  logic [1:0] res_status;
  logic [2:0] res_row, res_col;
  logic [7:0] res_byte;

  parity2d_checker #(.W(W), .ROWS(ROWS)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_par     (in_par),
    .in_last    (in_last),
    .res_valid  (res_valid),
    .res_status (res_status),
    .res_row    (res_row),
    .res_col    (res_col),
    .res_byte   (res_byte)
  );

  always #2ns clk = ~clk;

  int    checks   = 0;
  int    failures = 0;
  int    cyc      = 0;
  string cur_req  = "R7";

  // reference model state
  logic [7:0] q_data[$];
  logic       q_par[$];
  logic       e_valid = 1'b0;
  logic [1:0] e_status;
  logic [2:0] e_row, e_col;
  logic [7:0] e_byte;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic compare();
    checks++;
    if (res_valid !== e_valid) begin
      failures++;
      $display("FAIL %s res_valid: actual=%0b expected=%0b", cur_req, res_valid, e_valid);
    end else if (e_valid) begin
      if (res_status !== e_status || res_row !== e_row || res_col !== e_col || res_byte !== e_byte) begin
        failures++;
        $display("FAIL %s result: actual=st%0d r%0d c%0d b%02h expected=st%0d r%0d c%0d b%02h",
                 cur_req, res_status, res_row, res_col, res_byte,
                 e_status, e_row, e_col, e_byte);
      end
    end
  endtask

  task automatic model_end(input logic [7:0] pb);
    int nr = 0, nc = 0, rr = 0, cc = 0;
    logic [7:0] cx = pb;
    for (int i = 0; i < q_data.size(); i++) begin
      if (^{q_par[i], q_data[i]}) begin nr++; rr = i; end
      cx ^= q_data[i];
    end
    for (int c = 0; c < 8; c++) if (cx[c]) begin nc++; cc = c; end
    e_valid = 1'b1; e_row = 0; e_col = 0; e_byte = 0;
    if (nr == 0 && nc == 0) e_status = 0;
    else if (nr == 1 && nc == 1) begin
      e_status = 1; e_row = 3'(rr); e_col = 3'(cc);
      e_byte = q_data[rr] ^ (8'd1 << cc);
    end else if (nr == 1 && nc == 0) begin e_status = 2; e_row = 3'(rr); end
    else if (nr == 0 && nc == 1) begin e_status = 2; e_col = 3'(cc); end
    else e_status = 3;
    q_data.delete();
    q_par.delete();
  endtask

  task automatic beat(input logic v, input logic [7:0] d, input logic p, input logic l);
    @(negedge clk);
    compare();
    in_valid = v; in_data = d; in_par = p; in_last = l;
    e_valid = 1'b0;
    if (v && !l && q_data.size() < ROWS) begin
      q_data.push_back(d);
      q_par.push_back(p);
    end
    if (v && l) model_end(d);
  endtask

  // n rows; row frow gets flip mask fm (bit 8 = its parity bit); parity byte XOR pm
  task automatic send_frame(input int n, input int seed, input int frow, input logic [8:0] fm,
                            input logic [7:0] pm, input logic ppar, input bit gap);
    logic [7:0] pb = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'(i * 37 + seed * 11 + 5);
      logic       p = ^d;
      if (i < ROWS) pb ^= d;
      if (i == frow) begin d ^= fm[7:0]; p ^= fm[8]; end
      beat(1'b1, d, p, 1'b0);
      if (gap) beat(1'b0, 8'hA5 ^ 8'(i), 1'b1, 1'b1);
    end
    beat(1'b1, pb ^ pm, ppar, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_par = 1'b0; in_last = 1'b0;
    cur_req = "R7";
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    beat(1'b0, 8'h00, 1'b0, 1'b0);

    cur_req = "R3";  send_frame(8, 1, -1, 9'h000, 8'h00, 1'b0, 0);
    cur_req = "R4";  send_frame(8, 2, 5, 9'h004, 8'h00, 1'b0, 0);
    cur_req = "R4";  send_frame(8, 3, 0, 9'h080, 8'h00, 1'b0, 0);
    cur_req = "R1";  send_frame(6, 4, 3, 9'h001, 8'h00, 1'b0, 0);
    cur_req = "R5";  send_frame(8, 5, 3, 9'h100, 8'h00, 1'b0, 0);
    cur_req = "R5";  send_frame(8, 6, -1, 9'h000, 8'h10, 1'b0, 0);
    cur_req = "R6";  send_frame(8, 7, 2, 9'h042, 8'h00, 1'b0, 0);
    cur_req = "R6";  send_frame(8, 8, 5, 9'h004, 8'h40, 1'b0, 0);
    cur_req = "R10"; send_frame(7, 9, 6, 9'h020, 8'h00, 1'b0, 1);
    cur_req = "R2";  send_frame(8, 10, -1, 9'h000, 8'h00, 1'b1, 0);
    cur_req = "R8";  send_frame(3, 11, 1, 9'h008, 8'h00, 1'b0, 0);
    cur_req = "R8";  send_frame(0, 12, -1, 9'h000, 8'h00, 1'b0, 0);
    cur_req = "R8";  send_frame(0, 13, -1, 9'h000, 8'h21, 1'b0, 0);
    cur_req = "R8";  send_frame(2, 14, -1, 9'h000, 8'h00, 1'b0, 0);
    cur_req = "R9";  send_frame(11, 15, 9, 9'h011, 8'h00, 1'b0, 0);
    cur_req = "R9";  send_frame(10, 16, 7, 9'h002, 8'h00, 1'b0, 0);
    cur_req = "R7";
    beat(1'b0, 8'h00, 1'b0, 1'b0);
    beat(1'b0, 8'h00, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule